// File: doc/BRIEF.md
# Time-Slot Readout Character Encoder

This block feeds a character readout bus that works in ten numbered time slots. For each slot the bus host presents a slot number with a valid strobe. The block answers with one character code and a blank flag. Its inputs are a latched measurement and a set of module settings. The measurement is a half digit (a leading "1" or nothing), four BCD digits, a sign and an overrange flag. The settings are the decimal point position, three unit symbols, a sign disable and a least-significant-digit blank enable. Full scale of the measurement is 20000.

Slot 1 carries the decimal point position. Slot 2 carries the sign. Slot 3 carries the half digit. Slots 4 to 7 carry the BCD digits, most significant first. Slots 8 to 10 carry the unit symbols. Turning the codes into glyphs or bus currents is left to the consumer.

Both edges are valid/ready. The output holds one registered character. A request is taken when `slot_ready` is high, which is whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds and no new request is taken.

Top module: `rdo_slot_encoder`

## Requirements
- R1: After reset, `out_valid` is 0, `out_blank` is 1, `out_code` is 0 and `slot_ready` is 1.
- R2: A request accepted on a clock edge (`slot_valid` and `slot_ready` both high) appears on the output with `out_valid` high right after that edge. While `out_valid` is high and `out_ready` is low, the output does not change and `slot_ready` is low.
- R3: Slot 1 gives the code 0x20 plus `cfg_dp`, not blank.
- R4: Slot 2 gives 0x10 ("+") when `meas_neg` is 0 and 0x11 ("-") when it is 1.
- R5: Slot 2 gives 0x12 (">") whenever `meas_ovr` is 1, whatever the sign.
- R6: When `cfg_pol_off` is 1, slot 2 is blank. This takes priority over overrange.
- R7: Slot 3 gives 0x01 when `meas_half` is 1. Otherwise slot 3 is blank.
- R8: Slots 4, 5, 6 and 7 give the digit value 0x00 to 0x09 taken from `meas_bcd` bits [15:12], [11:8], [7:4] and [3:0], in that order.
- R9: Slot 7 is blank when `cfg_lsd_blank` is 1.
- R10: Slots 8, 9 and 10 give `cfg_units` bits [7:0], [15:8] and [23:16]. A unit byte of 0xFF gives a blank.
- R11: A request with slot number 0 or above 10 gives a blank.
- R12: Whenever `out_blank` is 1, `out_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_valid | input | 1 | Slot request valid |
| slot_ready | output | 1 | Request can be taken |
| slot_idx | input | 4 | Slot number, 1 to 10 |
| meas_half | input | 1 | Leading half digit is "1" |
| meas_bcd | input | 16 | Four BCD digits, most significant in the top nibble |
| meas_neg | input | 1 | Reading is negative |
| meas_ovr | input | 1 | Reading is over range |
| cfg_dp | input | 3 | Decimal point position |
| cfg_pol_off | input | 1 | Suppress the sign slot |
| cfg_lsd_blank | input | 1 | Blank the last digit |
| cfg_units | input | 24 | Three unit symbol bytes, first slot in the low byte |
| out_valid | output | 1 | Character valid |
| out_ready | input | 1 | Consumer takes the character |
| out_code | output | 8 | Character code |
| out_blank | output | 1 | Slot shows nothing |

## Verification
A vector table walks every slot number from 0 to 15 against one fixed reading, so each slot's source can be told apart from every other: distinct digits, a distinct decimal position and distinct unit bytes. The sign slot is tried with both signs, with overrange under a negative sign and with the sign disabled under overrange. This separates the order of precedence among those three inputs. The half-digit slot and the last-digit slot are each tried both shown and blanked. A directed stall then holds the consumer off while a second request waits, which shows whether the held character and the waiting request stay intact.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  localparam int CW = 8;

  localparam logic [CW-1:0] CODE_PLUS    = 8'h10;
  localparam logic [CW-1:0] CODE_MINUS   = 8'h11;
  localparam logic [CW-1:0] CODE_OVR     = 8'h12;
  localparam logic [CW-1:0] CODE_ONE     = 8'h01;
  localparam logic [CW-1:0] CODE_DP_BASE = 8'h20;
  localparam logic [CW-1:0] UNIT_NONE    = 8'hFF;

  typedef struct packed {
    logic          blank;
    logic [CW-1:0] code;
  } rdo_char_t;

  localparam rdo_char_t CHAR_BLANK = '{blank: 1'b1, code: '0};
endpackage

// File: rtl/rdo_digit_pick.sv
module rdo_digit_pick #(
  parameter int DIGITS = 4,
  parameter int PW     = 2
) (
  input  logic [4*DIGITS-1:0] bcd,
  input  logic [PW-1:0]       pos,
  output logic [3:0]          digit
);
  logic [3:0] dg [DIGITS];

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign dg[i] = bcd[4*(DIGITS-1-i) +: 4];
  end

  always_comb begin
    digit = 4'd0;
    for (int k = 0; k < DIGITS; k++)
      if (pos == PW'(k)) digit = dg[k];
  end
endmodule

// File: rtl/rdo_slot_map.sv
module rdo_slot_map
  import rdo_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int UNITS  = 3,
  parameter int SLOT_W = 4,
  parameter int DP_W   = 3
) (
  input  logic [SLOT_W-1:0]   slot_idx,
  input  logic                meas_half,
  input  logic [4*DIGITS-1:0] meas_bcd,
  input  logic                meas_neg,
  input  logic                meas_ovr,
  input  logic [DP_W-1:0]     cfg_dp,
  input  logic                cfg_pol_off,
  input  logic                cfg_lsd_blank,
  input  logic [CW*UNITS-1:0] cfg_units,
  output rdo_char_t           ch
);
  localparam int NUM_SLOTS  = 3 + DIGITS + UNITS;
  localparam int PW         = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam int UW         = (UNITS > 1) ? $clog2(UNITS) : 1;
  localparam logic [SLOT_W-1:0] S_DP    = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] S_SIGN  = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] S_HALF  = SLOT_W'(3);
  localparam logic [SLOT_W-1:0] S_DIG0  = SLOT_W'(4);
  localparam logic [SLOT_W-1:0] S_LSD   = SLOT_W'(3 + DIGITS);
  localparam logic [SLOT_W-1:0] S_UNIT0 = SLOT_W'(4 + DIGITS);
  localparam logic [SLOT_W-1:0] S_LAST  = SLOT_W'(NUM_SLOTS);

  logic [SLOT_W-1:0] dig_rel, unit_rel;
  logic [3:0]        digit;
  logic [CW-1:0]     unit_a [UNITS];
  logic [CW-1:0]     unit_sel;

  assign dig_rel  = slot_idx - S_DIG0;
  assign unit_rel = slot_idx - S_UNIT0;

  rdo_digit_pick #(.DIGITS(DIGITS), .PW(PW)) u_pick (
    .bcd  (meas_bcd),
    .pos  (dig_rel[PW-1:0]),
    .digit(digit)
  );

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    assign unit_a[u] = cfg_units[CW*u +: CW];
  end

  always_comb begin
    unit_sel = UNIT_NONE;
    for (int k = 0; k < UNITS; k++)
      if (unit_rel[UW-1:0] == UW'(k)) unit_sel = unit_a[k];
  end

  always_comb begin
    ch = CHAR_BLANK;
    if (slot_idx == S_DP) begin
      ch = '{blank: 1'b0, code: CODE_DP_BASE | CW'(cfg_dp)};
    end else if (slot_idx == S_SIGN) begin
      if (!cfg_pol_off) begin
        if (meas_ovr)      ch = '{blank: 1'b0, code: CODE_OVR};
        else if (meas_neg) ch = '{blank: 1'b0, code: CODE_MINUS};
        else               ch = '{blank: 1'b0, code: CODE_PLUS};
      end
    end else if (slot_idx == S_HALF) begin
      if (meas_half) ch = '{blank: 1'b0, code: CODE_ONE};
    end else if (slot_idx >= S_DIG0 && slot_idx <= S_LSD) begin
      if (!(slot_idx == S_LSD && cfg_lsd_blank))
        ch = '{blank: 1'b0, code: CW'(digit)};
    end else if (slot_idx >= S_UNIT0 && slot_idx <= S_LAST) begin
      if (unit_sel != UNIT_NONE) ch = '{blank: 1'b0, code: unit_sel};
    end
  end
endmodule

// File: rtl/rdo_out_stage.sv
module rdo_out_stage
  import rdo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  output logic      in_ready,
  input  rdo_char_t in_data,
  output logic      out_valid,
  input  logic      out_ready,
  output rdo_char_t out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= CHAR_BLANK;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rdo_slot_encoder.sv
module rdo_slot_encoder
  import rdo_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int UNITS  = 3,
  parameter int DP_W   = 3,
  parameter int SLOT_W = $clog2(3 + DIGITS + UNITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_valid,
  output logic                slot_ready,
  input  logic [SLOT_W-1:0]   slot_idx,
  input  logic                meas_half,
  input  logic [4*DIGITS-1:0] meas_bcd,
  input  logic                meas_neg,
  input  logic                meas_ovr,
  input  logic [DP_W-1:0]     cfg_dp,
  input  logic                cfg_pol_off,
  input  logic                cfg_lsd_blank,
  input  logic [CW*UNITS-1:0] cfg_units,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [CW-1:0]       out_code,
  output logic                out_blank
);
  rdo_char_t ch_next, ch_q;

  rdo_slot_map #(.DIGITS(DIGITS), .UNITS(UNITS), .SLOT_W(SLOT_W), .DP_W(DP_W)) u_map (
    .slot_idx     (slot_idx),
    .meas_half    (meas_half),
    .meas_bcd     (meas_bcd),
    .meas_neg     (meas_neg),
    .meas_ovr     (meas_ovr),
    .cfg_dp       (cfg_dp),
    .cfg_pol_off  (cfg_pol_off),
    .cfg_lsd_blank(cfg_lsd_blank),
    .cfg_units    (cfg_units),
    .ch           (ch_next)
  );

  rdo_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (slot_valid),
    .in_ready (slot_ready),
    .in_data  (ch_next),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (ch_q)
  );

  assign out_code  = ch_q.code;
  assign out_blank = ch_q.blank;
endmodule

// File: rtl/rdo_slot_encoder_chk.sv
module rdo_slot_encoder_chk
  import rdo_pkg::*;
#(
  parameter int SLOT_W    = 4,
  parameter int NUM_SLOTS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_valid,
  input logic              slot_ready,
  input logic [SLOT_W-1:0] slot_idx,
  input logic              meas_ovr,
  input logic              cfg_pol_off,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CW-1:0]     out_code,
  input logic              out_blank
);
  logic accept;
  assign accept = slot_valid && slot_ready;

  // R2
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_blank));

  // R12
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_blank |-> out_code == '0);

  // R11
  bad_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (slot_idx == '0 || slot_idx > SLOT_W'(NUM_SLOTS)) |=> out_blank);

  // R5
  ovr_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && slot_idx == SLOT_W'(2) && meas_ovr && !cfg_pol_off
      |=> out_code == CODE_OVR && !out_blank);
endmodule

bind rdo_slot_encoder rdo_slot_encoder_chk #(
  .SLOT_W(SLOT_W), .NUM_SLOTS(3 + DIGITS + UNITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_valid (slot_valid),
  .slot_ready (slot_ready),
  .slot_idx   (slot_idx),
  .meas_ovr   (meas_ovr),
  .cfg_pol_off(cfg_pol_off),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_code   (out_code),
  .out_blank  (out_blank)
);

// File: tb/rdo_slot_encoder_tb.sv
module rdo_slot_encoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_valid = 1'b0;
  logic        slot_ready;
  logic [3:0]  slot_idx = '0;
  logic        meas_half = 1'b0;
  logic [15:0] meas_bcd = 16'h3907;
  logic        meas_neg = 1'b0;
  logic        meas_ovr = 1'b0;
  logic [2:0]  cfg_dp = 3'd3;
  logic        cfg_pol_off = 1'b0;
  logic        cfg_lsd_blank = 1'b0;
  logic [23:0] cfg_units = {8'h56, 8'hFF, 8'h41};
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_code;
  logic        out_blank;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rdo_slot_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_ready(slot_ready),
    .slot_idx(slot_idx), .meas_half(meas_half), .meas_bcd(meas_bcd),
    .meas_neg(meas_neg), .meas_ovr(meas_ovr), .cfg_dp(cfg_dp),
    .cfg_pol_off(cfg_pol_off), .cfg_lsd_blank(cfg_lsd_blank), .cfg_units(cfg_units),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code), .out_blank(out_blank)
  );

  // {idx[4], neg, ovr, half, lsd_blank, pol_off, code[8], blank}
  localparam int NV = 18;
  localparam logic [17:0] VEC [NV] = '{
    {4'd1,  5'b00000, 8'h23, 1'b0},  // R3 decimal point 3
    {4'd2,  5'b00000, 8'h10, 1'b0},  // R4 plus
    {4'd2,  5'b10000, 8'h11, 1'b0},  // R4 minus
    {4'd2,  5'b11000, 8'h12, 1'b0},  // R5 overrange beats minus
    {4'd2,  5'b01001, 8'h00, 1'b1},  // R6 sign off beats overrange
    {4'd3,  5'b00100, 8'h01, 1'b0},  // R7 half digit shown
    {4'd3,  5'b00000, 8'h00, 1'b1},  // R7 half digit blank
    {4'd4,  5'b00000, 8'h03, 1'b0},  // R8 first digit
    {4'd5,  5'b00000, 8'h09, 1'b0},  // R8 second digit
    {4'd6,  5'b00000, 8'h00, 1'b0},  // R8 zero digit, not blank
    {4'd7,  5'b00000, 8'h07, 1'b0},  // R8 last digit
    {4'd7,  5'b00010, 8'h00, 1'b1},  // R9 last digit blanked
    {4'd8,  5'b00000, 8'h41, 1'b0},  // R10 first unit
    {4'd9,  5'b00000, 8'h00, 1'b1},  // R10 unit 0xFF blank
    {4'd10, 5'b00000, 8'h56, 1'b0},  // R10 third unit
    {4'd0,  5'b00000, 8'h00, 1'b1},  // R11 slot 0
    {4'd11, 5'b00000, 8'h00, 1'b1},  // R11 slot 11
    {4'd15, 5'b00000, 8'h00, 1'b1}   // R11 slot 15
  };
  localparam string TAG [NV] = '{"R3","R4","R4","R5","R6","R7","R7","R8","R8","R8",
                                 "R8","R9","R10","R10","R10","R11","R11","R11"};

  task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(input logic [3:0] idx);
    @(negedge clk);
    slot_idx   = idx;
    slot_valid = 1'b1;
    @(negedge clk);
    slot_valid = 1'b0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL R2: watchdog expired, got hang expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {out_valid, out_blank, slot_ready, 6'd0}, {1'b0, 1'b1, 1'b1, 6'd0});
    chk("R1", {1'b0, out_code}, 9'h000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {meas_neg, meas_ovr, meas_half, cfg_lsd_blank, cfg_pol_off} = VEC[i][13:9];
      send(VEC[i][17:14]);
      chk("R2", {8'd0, out_valid}, 9'd1);
      chk(TAG[i], {out_code, out_blank}, VEC[i][8:0]);
      // R12 blank implies zero code
      if (out_blank) chk("R12", {1'b0, out_code}, 9'h000);
    end
    {meas_neg, meas_ovr, meas_half, cfg_lsd_blank, cfg_pol_off} = 5'b00000;

    // R2 back-pressure: hold first character while second waits
    @(negedge clk);
    out_ready  = 1'b0;
    slot_idx   = 4'd4;
    slot_valid = 1'b1;
    @(negedge clk);
    slot_idx = 4'd5;
    chk("R2", {out_code, out_valid}, {8'h03, 1'b1});
    chk("R2", {8'd0, slot_ready}, 9'd0);
    @(negedge clk);
    chk("R2", {out_code, out_valid}, {8'h03, 1'b1});
    out_ready = 1'b1;
    @(negedge clk);
    slot_valid = 1'b0;
    chk("R2", {out_code, out_valid}, {8'h09, 1'b1});
    @(negedge clk);
    chk("R2", {8'd0, out_valid}, 9'd0);

    // R1 reset in mid-stream returns to the reset state
    send(4'd8);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", {out_valid, out_blank, out_code}, {1'b0, 1'b1, 8'h00});
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule